// File: doc/BRIEF.md
# Three-Phase External Bus Cycle Sequencer

This block carries single-byte memory and I/O transfers from the internal side of a chip to an external parallel bus. The bus cycle is divided into three phases, T1, T2 and T3, with optional wait phases between T2 and T3. Every phase lasts the same programmable number of system clocks. In T1 the block drives the 24-bit address and pulls one active-low chip select low. From T2 onward it holds the read or write strobe low, together with the memory or I/O space strobe. A slow device can stretch the cycle by holding the active-low wait line low. The read byte is captured when T3 ends, and at the same edge every strobe and the chip select are released.

Requests enter through a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the first clock edge where `req_valid` and `req_ready` are both high. While a transfer is running, a held `req_valid` waits. The response side has no back-pressure: `rsp_valid` is high for exactly one clock and `rsp_rdata` carries the captured byte. A new request can be accepted in the same cycle as that response pulse.

Top module: `zbus_seq`

## Requirements
- R1: `req_ready` is 1 only when no transfer is running, and an idle sequencer with `req_valid` low keeps every chip select, strobe and the data output enable inactive.
- R2: T1 starts on the clock after acceptance and lasts L clocks. During T1 `bus_addr` equals the request address, `bus_cs_n` has only bit `req_cs` at 0, and RD, WR, MREQ and IORQ are all 1.
- R3: T2 follows T1 and lasts L clocks. For a read `bus_rd_n` is 0; for a write `bus_wr_n` is 0. `bus_mreq_n` is 0 when `req_io`=0 and `bus_iorq_n` is 0 when `req_io`=1. These strobes stay low through any wait phases and T3.
- R4: Each wait phase lasts L clocks. At the end of T2, and at the end of each wait phase, the sequencer inserts another wait phase if `bus_wait_n` was low in the clock cycle before that phase's last clock. Otherwise it moves to T3.
- R5: T3 lasts L clocks, and no bus output changes during T3.
- R6: At the edge that ends T3, every chip select and strobe goes to 1 and the output enable goes to 0. `rsp_valid` is then 1 for one clock, with `rsp_rdata` equal to `bus_din` as it was during the last T3 clock.
- R7: L equals `cfg_phase_clks` (1 to 15) sampled at acceptance, and a value of 0 gives L=1. A change of `cfg_phase_clks` during a transfer has no effect on that transfer.
- R8: `bus_doe` is 1 from T1 through T3 of a write only, with `bus_dout` equal to the request's write byte.
- R9: After reset `req_ready`=1, `rsp_valid`=0, all chip selects and strobes are 1, `bus_doe`=0 and `bus_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phase_clks | input | 4 | Clocks per phase (0 acts as 1) |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_cs | input | 2 | Index of chip select to assert |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured at end of T3 |
| bus_addr | output | 24 | External address bus |
| bus_dout | output | 8 | External data bus, outgoing byte |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 8 | External data bus, incoming byte |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_mreq_n | output | 1 | Active-low memory space strobe |
| bus_iorq_n | output | 1 | Active-low I/O space strobe |
| bus_wait_n | input | 1 | Active-low wait request from device |

## Verification
The hardest case to reach is the wait decision at its exact boundary. A low wait level in the clock before T2's last clock must stretch the cycle, while the same level one clock later must not. This has to hold at every phase length, including L=1, where that early clock falls inside T1. The bench places a low window on `bus_wait_n` at cycle offsets computed from L, just before, exactly on and just after each decision point. From the window it works out the number of wait phases and the expected phase for every cycle. It then compares all bus outputs in every cycle of every transfer.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } zbus_phase_e;
endpackage

// File: rtl/zbus_phase_timer.sv
module zbus_phase_timer #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CFG_W-1:0] len,
  output logic             last
);
  logic [CFG_W-1:0] cnt_q;

  // every phase has the same length, so the count simply wraps at each boundary
  assign last = busy && (cnt_q == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!busy || last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < len));
endmodule

// File: rtl/zbus_req_hold.sv
module zbus_req_hold #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int CS_IDX_W = 2,
  parameter int CFG_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic                in_write,
  input  logic                in_io,
  input  logic [CS_IDX_W-1:0] in_cs,
  input  logic [CFG_W-1:0]    in_cfg,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic [DATA_W-1:0]   cur_wdata,
  output logic                cur_write,
  output logic                cur_io,
  output logic [CS_IDX_W-1:0] cur_cs,
  output logic [CFG_W-1:0]    len_q
);
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q, io_q;
  logic [CS_IDX_W-1:0] cs_q;
  logic [CFG_W-1:0]    len_eff;

  assign len_eff = (in_cfg == '0) ? CFG_W'(1) : in_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
      cs_q    <= '0;
      len_q   <= CFG_W'(1);
    end else if (take) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      write_q <= in_write;
      io_q    <= in_io;
      cs_q    <= in_cs;
      len_q   <= len_eff;
    end
  end

  // on the accept cycle the strobe registers must see the new request directly
  assign cur_addr  = take ? in_addr  : addr_q;
  assign cur_wdata = take ? in_wdata : wdata_q;
  assign cur_write = take ? in_write : write_q;
  assign cur_io    = take ? in_io    : io_q;
  assign cur_cs    = take ? in_cs    : cs_q;

  p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0);
endmodule

// File: rtl/zbus_strobe_gen.sv
module zbus_strobe_gen
  import zbus_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int NUM_CS   = 4,
  parameter int CS_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  zbus_phase_e         ph_next,
  input  logic                write,
  input  logic                io,
  input  logic [CS_IDX_W-1:0] cs_idx,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_doe,
  output logic [NUM_CS-1:0]   bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                bus_mreq_n,
  output logic                bus_iorq_n
);
  logic              active, strobe;
  logic [NUM_CS-1:0] cs_d;

  assign active = (ph_next != PH_IDLE);
  assign strobe = (ph_next == PH_T2) || (ph_next == PH_TW) || (ph_next == PH_T3);

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      cs_d[i] = !(active && (cs_idx == CS_IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr   <= '0;
      bus_dout   <= '0;
      bus_doe    <= 1'b0;
      bus_cs_n   <= '1;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
      bus_mreq_n <= 1'b1;
      bus_iorq_n <= 1'b1;
    end else begin
      if (active)          bus_addr <= addr;
      if (active && write) bus_dout <= wdata;
      bus_doe    <= active && write;
      bus_cs_n   <= cs_d;
      bus_rd_n   <= !(strobe && !write);
      bus_wr_n   <= !(strobe && write);
      bus_mreq_n <= !(strobe && !io);
      bus_iorq_n <= !(strobe && io);
    end
  end

  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n);
  p_space_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mreq_n || bus_iorq_n);
  p_cs_onehot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_strobe_has_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n));
  p_doe_not_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_rd_n && !(&bus_cs_n)));
endmodule

// File: rtl/zbus_seq.sv
module zbus_seq
  import zbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int CFG_W  = 4,
  localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_phase_clks,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_write,
  input  logic                req_io,
  input  logic [CS_IDX_W-1:0] req_cs,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_doe,
  input  logic [DATA_W-1:0]   bus_din,
  output logic [NUM_CS-1:0]   bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                bus_mreq_n,
  output logic                bus_iorq_n,
  input  logic                bus_wait_n
);
  zbus_phase_e         phase_q, ph_next;
  logic                take, last, busy, wait_q, done;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_wdata;
  logic                cur_write, cur_io;
  logic [CS_IDX_W-1:0] cur_cs;
  logic [CFG_W-1:0]    len_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign take      = req_ready && req_valid;
  assign busy      = !req_ready;
  assign done      = (phase_q == PH_T3) && last;

  zbus_req_hold #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_IDX_W(CS_IDX_W), .CFG_W(CFG_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_write(req_write),
    .in_io(req_io), .in_cs(req_cs), .in_cfg(cfg_phase_clks),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_write(cur_write),
    .cur_io(cur_io), .cur_cs(cur_cs), .len_q(len_q)
  );

  zbus_phase_timer #(.CFG_W(CFG_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .len(len_q), .last(last)
  );

  // wait line registered once: a decision at a phase's last clock sees the level one clock earlier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b1;
    else        wait_q <= bus_wait_n;
  end

  always_comb begin
    ph_next = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) ph_next = PH_T1;
      PH_T1:   if (last) ph_next = PH_T2;
      PH_T2:   if (last) ph_next = wait_q ? PH_T3 : PH_TW;
      PH_TW:   if (last) ph_next = wait_q ? PH_T3 : PH_TW;
      PH_T3:   if (last) ph_next = PH_IDLE;
      default: ph_next = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      phase_q   <= ph_next;
      rsp_valid <= done;
      if (done) rsp_rdata <= bus_din;
    end
  end

  zbus_strobe_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .ph_next(ph_next),
    .write(cur_write), .io(cur_io), .cs_idx(cur_cs),
    .addr(cur_addr), .wdata(cur_wdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n)
  );

  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe));
  p_wait_blocks_t3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_T2 || phase_q == PH_TW) && last && !wait_q) |=> (phase_q == PH_TW));
  p_t3_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T3 && $past(phase_q == PH_T3))
      |-> $stable({bus_addr, bus_dout, bus_doe, bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n}));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&bus_cs_n && bus_mreq_n && bus_iorq_n && !bus_doe));
endmodule

// File: tb/zbus_seq_bench.sv
`timescale 1ns/100ps
module zbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_phase_clks = 4'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic [1:0]  req_cs = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [23:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic [7:0]  bus_din = '0;
  logic [3:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n;
  logic        bus_wait_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  zbus_seq u_zbus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_phase_clks(cfg_phase_clks),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io), .req_cs(req_cs),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n), .bus_wait_n(bus_wait_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctl_now();
    return {21'd0, bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n, bus_doe, req_ready, rsp_valid};
  endfunction

  // ph: 0 idle, 1 T1, 2 T2, 3 wait, 4 T3
  function automatic logic [31:0] ctl_exp(input int ph, input bit wr, input bit io, input int cs, input bit rsp);
    logic [3:0] csx;
    bit stb;
    csx = (ph == 0) ? 4'hF : ~(4'b0001 << cs);
    stb = (ph >= 2);
    return {21'd0, csx, !(stb && !wr), !(stb && wr), !(stb && !io), !(stb && io),
            (ph != 0) && wr, ph == 0, rsp};
  endfunction

  task automatic run_xfer(input int cfg, input int cfg_mid, input bit wr, input bit io, input int cs,
                          input logic [23:0] addr, input logic [7:0] wd, input logic [7:0] din,
                          input int lo_s, input int lo_e, input string tag);
    int n, w, tot, ph;
    string ptag;
    n = (cfg == 0) ? 1 : cfg;
    w = 0;
    // R4: decision at the end of T2 / each wait phase uses the level one clock before its last clock
    while (w < 64 && (2*n + w*n - 2) >= lo_s && (2*n + w*n - 2) < lo_e) w++;
    tot = 3*n + w*n;
    cfg_phase_clks = 4'(cfg);
    req_valid = 1'b1; req_addr = addr; req_wdata = wd; req_write = wr; req_io = io;
    req_cs = 2'(cs); bus_din = din; bus_wait_n = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= tot; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      if (c == 1) cfg_phase_clks = 4'(cfg_mid);
      bus_wait_n = !(c >= lo_s && c < lo_e);
      if (c < n) ph = 1;
      else if (c < 2*n) ph = 2;
      else if (c < 2*n + w*n) ph = 3;
      else if (c < tot) ph = 4;
      else ph = 0;
      case (ph)
        1: ptag = "R2";
        2: ptag = "R3";
        3: ptag = "R4";
        4: ptag = "R5";
        default: ptag = "R6";
      endcase
      if (tag != "") ptag = {ptag, "/", tag};
      chk(ctl_now() == ctl_exp(ph, wr, io, cs, ph == 0), ptag, ctl_now(), ctl_exp(ph, wr, io, cs, ph == 0));
      if (ph != 0) chk(bus_addr == addr, "R2 addr", 32'(bus_addr), 32'(addr));
      if (ph != 0 && wr) chk(bus_dout == wd, "R8 dout", 32'(bus_dout), 32'(wd));
      if (ph == 0) chk(rsp_rdata == din, "R6 rdata", 32'(rsp_rdata), 32'(din));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(ctl_now() == ctl_exp(0, 0, 0, 0, 0), "R9", ctl_now(), ctl_exp(0, 0, 0, 0, 0));
    chk(bus_addr == 24'd0, "R9 addr", 32'(bus_addr), 32'd0);
    // R1: idle with no request stays quiet
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ctl_now() == ctl_exp(0, 0, 0, 0, 0), "R1", ctl_now(), ctl_exp(0, 0, 0, 0, 0));
    end
    k = 0;
    for (int n = 1; n <= 4; n++)
      for (int wr = 0; wr < 2; wr++)
        for (int io = 0; io < 2; io++)
          for (int p = 0; p < 4; p++) begin
            int ls, le;
            case (p)
              0: begin ls = 0; le = 0; end
              1: begin ls = 2*n - 2; le = 2*n - 1; end
              2: begin ls = 0; le = 4*n; end
              default: begin ls = 2*n - 1; le = 4*n; end
            endcase
            run_xfer(n, n, wr[0], io[0], k % 4, 24'h10_0000 + 24'(k * 24'h0111),
                     8'(8'h5A ^ k), 8'(8'hC3 + k), ls, le, "");
            k++;
          end
    // R7: setting of 0 acts as one clock per phase
    run_xfer(0, 0, 1'b0, 1'b0, 2, 24'hABCDEF, 8'h11, 8'h77, 0, 0, "R7");
    run_xfer(0, 0, 1'b1, 1'b1, 3, 24'h000001, 8'h22, 8'h88, 0, 2, "R7");
    // R7: largest setting with waits
    run_xfer(15, 15, 1'b0, 1'b1, 1, 24'hFFFFFF, 8'h33, 8'h99, 0, 40, "R7");
    // R7: mid-transfer change ignored
    run_xfer(3, 7, 1'b1, 1'b0, 0, 24'h123456, 8'h44, 8'hAA, 4, 5, "R7");
    run_xfer(5, 1, 1'b0, 1'b0, 2, 24'h654321, 8'h55, 8'hBB, 0, 0, "R7");
    @(negedge clk);
    chk(ctl_now() == ctl_exp(0, 0, 0, 0, 0), "R1 end", ctl_now(), ctl_exp(0, 0, 0, 0, 0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule